// File: doc/BRIEF.md
# Two-Floor Lift Sequencer

This block is the control sequencer for a lift car that serves two landings. It watches landing call buttons, in-car destination buttons, landing presence and approach sensors, door end-of-travel flags and an external dwell-timer flag. From these it commands the hoist direction, a slow-down request, a dwell-timer start pulse and the door open and close drives. The timer, the hoist drive, the door operators and every safety interlock sit outside the block. Their status arrives as plain inputs.

The block holds a five-bit one-hot state with five states: three park phases (doors opening, dwelling, doors closing), travelling up, and travelling down. Some outputs depend on the state alone and some depend on the state together with the live inputs, all decoded combinationally. A departure request exists when the doors are fully open and the button for the other landing is pressed: landing 2 while parked at landing 1, or landing 1 while parked at landing 2. The car always parks with its doors open at the landing it reached last.

Top module: `lift2_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the car in the doors-opening park phase. On the first cycle after reset, with the car at landing 1 and the doors not fully open, `door_open_cmd` is 1 and every other output is 0.
- R2: In the doors-opening phase, `timer_start` is 1 only in cycles where a departure request exists. A departure request needs `door_open_done`=1 and a press of the other landing's hall or car button. A press for the current landing has no effect. When `timer_start` is 1 the next state is the dwelling phase; otherwise the state does not change.
- R3: In the doors-opening phase, `door_open_cmd` equals the inverse of `door_open_done`.
- R4: In the dwelling phase all outputs are 0. The phase moves to doors-closing in the cycle after `wait_expired`=1 and otherwise stays.
- R5: In the doors-closing phase, `door_close_cmd` is 1 while `door_shut_done`=0 and either presence sensor is 1. When `door_shut_done`=1, the car goes down if `at_floor_2`=1, which takes priority. Otherwise it goes up if `at_floor_1`=1. With neither presence sensor set, the state holds.
- R6: While travelling down, `motor_down` is 1 and `slow_down` follows `near_floor_1` only. The car returns to doors-opening in the cycle after `at_floor_1`=1.
- R7: While travelling up, `motor_up` is 1 and `slow_down` follows `near_floor_2` only. The car returns to doors-opening in the cycle after `at_floor_2`=1.
- R8: `motor_up` and `motor_down` are 0 in all three park phases and are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hall_call_1 | input | 1 | Landing call button at landing 1 |
| hall_call_2 | input | 1 | Landing call button at landing 2 |
| car_go_1 | input | 1 | In-car button for landing 1 |
| car_go_2 | input | 1 | In-car button for landing 2 |
| at_floor_1 | input | 1 | Car level with landing 1 |
| at_floor_2 | input | 1 | Car level with landing 2 |
| near_floor_1 | input | 1 | Car approaching landing 1 |
| near_floor_2 | input | 1 | Car approaching landing 2 |
| door_open_done | input | 1 | Doors fully open |
| door_shut_done | input | 1 | Doors fully closed |
| wait_expired | input | 1 | External dwell timer has run out |
| motor_up | output | 1 | Drive car upward |
| motor_down | output | 1 | Drive car downward |
| timer_start | output | 1 | Load and start the dwell timer |
| slow_down | output | 1 | Reduce hoist speed on approach |
| door_open_cmd | output | 1 | Drive doors open |
| door_close_cmd | output | 1 | Drive doors closed |

## Verification
Every output is a function of the registered state and the present inputs. An output that follows the inputs is therefore due in the same cycle the stimulus is applied, and an effect on the state shows up in the outputs one clock edge later. Each bench vector drives its inputs just after a rising edge, compares the outputs partway through that cycle, and only then lets the next edge advance the state. A state change is always confirmed by the outputs of the vector that follows. The reset and priority cases follow the same rule: one edge under reset, then a check in the next cycle.

// File: rtl/lift2_pkg.sv
// Shared definitions for the two-landing lift sequencer.
// Assumes a one-hot state code; bit positions fix the state order.
package lift2_pkg;
    localparam int ST_W = 5;
    localparam int B_OPEN  = 0;
    localparam int B_DWELL = 1;
    localparam int B_SHUT  = 2;
    localparam int B_DOWN  = 3;
    localparam int B_UP    = 4;

    typedef logic [ST_W-1:0] st_vec_t;

    localparam st_vec_t ST_OPEN  = st_vec_t'(1) << B_OPEN;
    localparam st_vec_t ST_DWELL = st_vec_t'(1) << B_DWELL;
    localparam st_vec_t ST_SHUT  = st_vec_t'(1) << B_SHUT;
    localparam st_vec_t ST_DOWN  = st_vec_t'(1) << B_DOWN;
    localparam st_vec_t ST_UP    = st_vec_t'(1) << B_UP;

    typedef struct packed {
        logic call1;
        logic call2;
        logic go1;
        logic go2;
        logic lvl1;
        logic lvl2;
        logic near1;
        logic near2;
        logic dopen;
        logic dshut;
        logic tmo;
    } lift_in_t;
endpackage

// File: rtl/lift2_req_term.sv
// Departure request detector.
// Asserts when the doors are fully open and the other landing is requested.
// Assumes at most one presence sensor is meaningful while parked.
module lift2_req_term
    import lift2_pkg::*;
(
    input  lift_in_t in_i,
    output logic     req_o
);
    // Combine presence, buttons and door state into the request term.
    always_comb begin
        req_o = in_i.dopen &
                ((in_i.lvl1 & (in_i.call2 | in_i.go2)) |
                 (in_i.lvl2 & (in_i.call1 | in_i.go1)));
    end
endmodule

// File: rtl/lift2_next.sv
// Next-state logic for the one-hot sequencer.
// Any code that is not one of the five legal codes returns to the
// doors-opening phase.
module lift2_next
    import lift2_pkg::*;
(
    input  st_vec_t  cur_i,
    input  lift_in_t in_i,
    input  logic     req_i,
    output st_vec_t  nxt_o
);
    // Select the successor state from the current code and inputs.
    always_comb begin
        nxt_o = ST_OPEN;
        case (cur_i)
            ST_OPEN:  nxt_o = req_i ? ST_DWELL : ST_OPEN;
            ST_DWELL: nxt_o = in_i.tmo ? ST_SHUT : ST_DWELL;
            ST_SHUT: begin
                if (in_i.dshut && in_i.lvl2)      nxt_o = ST_DOWN;
                else if (in_i.dshut && in_i.lvl1) nxt_o = ST_UP;
                else                              nxt_o = ST_SHUT;
            end
            ST_DOWN:  nxt_o = in_i.lvl1 ? ST_OPEN : ST_DOWN;
            ST_UP:    nxt_o = in_i.lvl2 ? ST_OPEN : ST_UP;
            default:  nxt_o = ST_OPEN;
        endcase
    end
endmodule

// File: rtl/lift2_out_dec.sv
// Output decoder: state-only actions plus state-and-input actions.
// Decodes by exact code match, so an illegal code drives every output to 0.
module lift2_out_dec
    import lift2_pkg::*;
(
    input  st_vec_t  cur_i,
    input  lift_in_t in_i,
    input  logic     req_i,
    output logic     up_o,
    output logic     down_o,
    output logic     tstart_o,
    output logic     slow_o,
    output logic     open_o,
    output logic     close_o
);
    logic in_open, in_shut, in_down, in_up;

    // Exact-match state decode.
    always_comb begin
        in_open = (cur_i == ST_OPEN);
        in_shut = (cur_i == ST_SHUT);
        in_down = (cur_i == ST_DOWN);
        in_up   = (cur_i == ST_UP);
    end

    // Form each output action from its state and output condition.
    always_comb begin
        up_o     = in_up;
        down_o   = in_down;
        slow_o   = (in_down & in_i.near1) | (in_up & in_i.near2);
        tstart_o = in_open & req_i;
        open_o   = in_open & ~in_i.dopen;
        close_o  = in_shut & ~in_i.dshut & (in_i.lvl1 | in_i.lvl2);
    end
endmodule

// File: rtl/lift2_state_reg.sv
// State register with synchronous active-low reset.
// Assumes RST_VAL is a legal state code.
module lift2_state_reg #(
    parameter int              W       = 5,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Load the next state, or the reset code when reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= RST_VAL;
        else        q_o <= d_i;
    end
endmodule

// File: rtl/lift2_ctrl.sv
// Top of the two-landing lift sequencer.
// Packs the inputs, holds the one-hot state and decodes the outputs.
// Assumes external logic provides the timer, the hoist and door drives, and the interlocks.
module lift2_ctrl
    import lift2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hall_call_1,
    input  logic hall_call_2,
    input  logic car_go_1,
    input  logic car_go_2,
    input  logic at_floor_1,
    input  logic at_floor_2,
    input  logic near_floor_1,
    input  logic near_floor_2,
    input  logic door_open_done,
    input  logic door_shut_done,
    input  logic wait_expired,
    output logic motor_up,
    output logic motor_down,
    output logic timer_start,
    output logic slow_down,
    output logic door_open_cmd,
    output logic door_close_cmd
);
    lift_in_t in_s;
    st_vec_t  cur_s, nxt_s;
    logic     req_s;

    // Gather the inputs into one record.
    always_comb begin
        in_s = '{call1: hall_call_1, call2: hall_call_2,
                 go1: car_go_1, go2: car_go_2,
                 lvl1: at_floor_1, lvl2: at_floor_2,
                 near1: near_floor_1, near2: near_floor_2,
                 dopen: door_open_done, dshut: door_shut_done,
                 tmo: wait_expired};
    end

    lift2_req_term req_i (.in_i(in_s), .req_o(req_s));

    lift2_next nxt_i (.cur_i(cur_s), .in_i(in_s), .req_i(req_s), .nxt_o(nxt_s));

    lift2_state_reg #(.W(ST_W), .RST_VAL(ST_OPEN)) st_i (
        .clk(clk), .rst_n(rst_n), .d_i(nxt_s), .q_o(cur_s)
    );

    lift2_out_dec dec_i (
        .cur_i(cur_s), .in_i(in_s), .req_i(req_s),
        .up_o(motor_up), .down_o(motor_down), .tstart_o(timer_start),
        .slow_o(slow_down), .open_o(door_open_cmd), .close_o(door_close_cmd)
    );
endmodule

// File: rtl/lift2_ctrl_chk.sv
// Port-level temporal checks for lift2_ctrl, attached by bind.
module lift2_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic at_floor_1,
    input logic at_floor_2,
    input logic motor_up,
    input logic motor_down,
    input logic timer_start,
    input logic slow_down,
    input logic door_close_cmd
);
    // R8
    up_down_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(motor_up && motor_down));

    // R1
    reset_parks_chk: assert property (@(posedge clk)
        !rst_n |=> !motor_up && !motor_down && !door_close_cmd);

    // R2
    dwell_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_start |=> !timer_start && !motor_up && !motor_down && !door_close_cmd);

    // R5
    closing_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        door_close_cmd |=> !motor_up && !motor_down);

    // R6
    down_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
        motor_down && at_floor_1 |=> !motor_down && !motor_up);

    // R7
    up_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
        motor_up && at_floor_2 |=> !motor_up && !motor_down);

    // R6
    slow_needs_travel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_down |-> (motor_up || motor_down));
endmodule

bind lift2_ctrl lift2_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n),
    .at_floor_1(at_floor_1), .at_floor_2(at_floor_2),
    .motor_up(motor_up), .motor_down(motor_down),
    .timer_start(timer_start), .slow_down(slow_down),
    .door_close_cmd(door_close_cmd)
);

// File: tb/lift2_ctrl_tb_top.sv
// Table-driven bench for lift2_ctrl followed by directed reset and priority tests.
module lift2_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [10:0] stim = '0;
    logic [5:0]  outs;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    logic m_up, m_dn, t_st, sl, d_op, d_cl;
    assign outs = {m_up, m_dn, t_st, sl, d_op, d_cl};

    // stim bits: call1 call2 go1 go2 lvl1 lvl2 near1 near2 dopen dshut tmo
    lift2_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .hall_call_1(stim[10]), .hall_call_2(stim[9]),
        .car_go_1(stim[8]), .car_go_2(stim[7]),
        .at_floor_1(stim[6]), .at_floor_2(stim[5]),
        .near_floor_1(stim[4]), .near_floor_2(stim[3]),
        .door_open_done(stim[2]), .door_shut_done(stim[1]),
        .wait_expired(stim[0]),
        .motor_up(m_up), .motor_down(m_dn), .timer_start(t_st),
        .slow_down(sl), .door_open_cmd(d_op), .door_close_cmd(d_cl)
    );

    // Entry: {req id, stimulus, expected {up,down,tstart,slow,open,close}}
    localparam int NV = 24;
    localparam logic [20:0] VEC [NV] = '{
        {4'd1, 11'b00_00_10_00_0_0_0, 6'b000010}, // R1 parked at 1, doors opening
        {4'd2, 11'b00_00_10_00_1_0_0, 6'b000000}, // R2 no request
        {4'd2, 11'b10_00_10_00_1_0_0, 6'b000000}, // R2 own landing ignored
        {4'd2, 11'b01_00_10_00_0_0_0, 6'b000010}, // R2 request needs open doors
        {4'd2, 11'b01_00_10_00_1_0_0, 6'b001000}, // R2 start timer -> dwell
        {4'd4, 11'b01_00_10_00_1_0_0, 6'b000000}, // R4 dwell waits
        {4'd4, 11'b01_00_10_00_1_0_1, 6'b000000}, // R4 expiry -> closing
        {4'd5, 11'b00_00_00_00_0_1_0, 6'b000000}, // R5 shut, no landing: hold
        {4'd5, 11'b00_00_00_00_0_0_0, 6'b000000}, // R5 no landing: no close
        {4'd5, 11'b00_00_10_00_0_0_0, 6'b000001}, // R5 close drive
        {4'd5, 11'b00_00_10_00_0_1_0, 6'b000000}, // R5 shut at 1 -> up
        {4'd7, 11'b00_00_00_00_0_0_0, 6'b100000}, // R7 travelling up
        {4'd7, 11'b00_00_00_01_0_0_0, 6'b100100}, // R7 slow on near2
        {4'd7, 11'b00_00_00_10_0_0_0, 6'b100000}, // R7 near1 ignored
        {4'd7, 11'b00_00_01_01_0_0_0, 6'b100100}, // R7 arrive at 2 -> open
        {4'd3, 11'b00_00_01_00_0_0_0, 6'b000010}, // R3 doors opening at 2
        {4'd2, 11'b00_10_01_00_1_0_0, 6'b001000}, // R2 car button 1 -> dwell
        {4'd4, 11'b00_00_01_00_1_0_1, 6'b000000}, // R4 expiry -> closing
        {4'd5, 11'b00_00_01_00_0_0_0, 6'b000001}, // R5 close drive at 2
        {4'd5, 11'b00_00_01_00_0_1_0, 6'b000000}, // R5 shut at 2 -> down
        {4'd6, 11'b00_00_00_10_0_0_0, 6'b010100}, // R6 slow on near1
        {4'd6, 11'b00_00_00_01_0_0_0, 6'b010000}, // R6 near2 ignored
        {4'd6, 11'b00_00_10_00_0_0_0, 6'b010000}, // R6 arrive at 1 -> open
        {4'd3, 11'b00_00_10_00_0_0_0, 6'b000010}  // R3 doors opening at 1
    };

    function automatic string tag_of(input logic [3:0] id);
        case (id)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input logic [5:0] got, input logic [5:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b", tag, got, exp);
        end
    endtask

    task automatic chk_excl();
        checks++;
        if (m_up && m_dn) begin
            errors++;
            $display("FAIL R8: up=%b down=%b expected not both", m_up, m_dn);
        end
    endtask

    // Apply stimulus after an edge, check mid-cycle, then advance one edge.
    task automatic step(input logic [10:0] s, input logic [5:0] exp, input string tag);
        stim = s;
        #2;
        chk(outs, exp, tag);
        chk_excl();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_reset();
        rst_n = 1'b0;
        stim = '0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        stim = 11'b00_00_10_00_0_0_0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][16:6], VEC[i][5:0], tag_of(VEC[i][20:17]));
        end

        // R5 both presence sensors with doors shut: down takes priority
        step(11'b01_00_10_00_1_0_0, 6'b001000, "R2");
        step(11'b00_00_10_00_0_0_1, 6'b000000, "R4");
        step(11'b00_00_11_00_0_1_0, 6'b000000, "R5");
        step(11'b00_00_00_00_0_0_0, 6'b010000, "R5");

        // R1 reset while travelling down returns to doors-opening
        pulse_reset();
        step(11'b00_00_10_00_0_0_0, 6'b000010, "R1");

        // R1 reset from dwell: a request starts the timer again at once
        step(11'b01_00_10_00_1_0_0, 6'b001000, "R2");
        pulse_reset();
        step(11'b01_00_10_00_1_0_0, 6'b001000, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule